// File: doc/BRIEF.md
# PIO strobe timing generator

This block turns single register-bus requests into programmed-I/O cycles on a parallel ATA cable. A request carries an address offset, a read/write flag and write data. The block decodes the offset into the two chip selects and the three register address lines. It then drives the read or write strobe for a programmed number of clocks, waits out a programmed recovery time and reports completion back to the bus. For reads it captures the drive's data bus at the end of the strobe.

Timing is held per device in four programmable registers. The data port and the other task-file registers each have their own pair of registers: one holds the strobe width and the other the recovery width. Every register holds one byte per device, and each byte stores a clock count minus one. The device is chosen by bit 4 of the most recent write to the device register. A control register holds an interface enable, and while it is clear no cable cycle is produced. The reset values of the timing registers give a 600 ns cycle with the slowest PIO timing, derived from the clock period parameter.

Top module: `pio_timing_gen`

## Requirements
- R1: Within three clocks of reset release, with no request pending, the block is idle: `acc_ready`=1, `acc_done`=0, `ata_cs_n`=2'b11, both strobes high and `ata_dd_oe`=0.
- R2: Offsets 0x1F0 to 0x1F7 drive `ata_cs_n`=2'b10 with `ata_da`=offset[2:0]. Offset 0x3F6 drives `ata_cs_n`=2'b01 with `ata_da`=6. While no cycle is in progress `ata_cs_n`=2'b11.
- R3: Chip select and address are valid and stable for exactly one clock before the strobe falls, and they are held until the cycle ends.
- R4: A read drives only `ata_dior_n` low and a write drives only `ata_diow_n` low. The strobe stays low for (strobe field + 1) clocks. Offset 0x1F0 uses the data pair and every other decoded offset uses the register pair.
- R5: After the strobe rises, (recovery field + 1) clocks pass before `acc_done` pulses for one clock. `acc_ready` stays low from acceptance until that pulse.
- R6: After reset, for both devices the data pair gives ceil(165/T) strobe clocks and the register pair gives ceil(290/T) strobe clocks. In both cases strobe plus recovery span ceil(600/T) clocks, where T is the clock period in ns.
- R7: A configuration write goes to the register named by `cfg_sel`: 0 is data strobe, 1 is data recovery, 2 is register strobe, 3 is register recovery. `cfg_be[0]` writes device 0's byte from `cfg_wdata[7:0]`, `cfg_be[1]` writes device 1's byte from `cfg_wdata[15:8]`, and a byte with its enable clear keeps its value.
- R8: An accepted write to offset 0x1F6 sets the selected device to `acc_wdata[4]`. That write itself still uses the timing of the previously selected device.
- R9: `cfg_sel`=4 with `cfg_be[1]` set loads the interface enable from `cfg_wdata[15]`, and reset sets it. While it is clear, and for any offset that is not decoded, an accepted request produces no chip select and no strobe. `acc_done` pulses in the next clock, a read returns 0, and a device-register write does not change the device.
- R10: Read data is sampled on the last strobe clock. Offset 0x1F0 returns all 16 bits, and the other offsets return `ata_dd_in[7:0]` zero-extended. A write drives `acc_wdata` on `ata_dd_out` with `ata_dd_oe` high through setup and strobe. A read never raises `ata_dd_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_be | input | 2 | Per-device byte enables |
| cfg_wdata | input | 16 | Configuration write data |
| acc_req | input | 1 | Access request |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 10 | Register offset |
| acc_wdata | input | 16 | Write data |
| acc_ready | output | 1 | Idle, request can be accepted |
| acc_done | output | 1 | One-clock completion pulse |
| acc_rdata | output | 16 | Captured read data |
| ata_cs_n | output | 2 | Chip selects, active low |
| ata_da | output | 3 | Register address lines |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_out | output | 16 | Data bus out |
| ata_dd_oe | output | 1 | Data bus output enable |
| ata_dd_in | input | 16 | Data bus in |

## Verification
A request is accepted on the rising edge where `acc_req` and `acc_ready` are both high. Chip select and address appear in the clock after that edge. The strobe falls one clock later and lasts (strobe field + 1) clocks. Recovery then takes (recovery field + 1) clocks, and `acc_done` rises in the clock after recovery ends. A bypassed request raises `acc_done` in the very first clock after acceptance. The bench samples every output on the falling edge and classifies each clock as setup, strobe or recovery until `acc_done` appears. It compares those clock counts, and the chip select, address and data seen in the matching phases, against values computed from the 5 ns clock.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
package pio_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_ACTIVE, ST_RECOVER} cyc_state_e;

  localparam logic [2:0] CFG_DATA_STB = 3'd0;
  localparam logic [2:0] CFG_DATA_RCV = 3'd1;
  localparam logic [2:0] CFG_REG_STB  = 3'd2;
  localparam logic [2:0] CFG_REG_RCV  = 3'd3;
  localparam logic [2:0] CFG_CTRL     = 3'd4;

  localparam int unsigned CMD_BASE = 32'h1F0;
  localparam int unsigned ALT_ADDR = 32'h3F6;
  localparam logic [2:0]  DEV_OFS  = 3'd6;
endpackage

// File: rtl/pio_timing_regs.sv
`timescale 1ns/1ps
module pio_timing_regs import pio_pkg::*; #(
  parameter int FW = 8,
  parameter int NDEV = 2,
  parameter logic [FW-1:0] DSTB_RST = '0,
  parameter logic [FW-1:0] DRCV_RST = '0,
  parameter logic [FW-1:0] RSTB_RST = '0,
  parameter logic [FW-1:0] RRCV_RST = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [2:0]             cfg_sel,
  input  logic [NDEV-1:0]        cfg_be,
  input  logic [NDEV*FW-1:0]     cfg_wdata,
  output logic [4*NDEV*FW-1:0]   tim_flat,
  output logic                   en
);
  localparam int NREG = 4;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    for (genvar d = 0; d < NDEV; d++) begin : g_dev
      localparam logic [FW-1:0] RV = (r == 0) ? DSTB_RST :
                                     (r == 1) ? DRCV_RST :
                                     (r == 2) ? RSTB_RST : RRCV_RST;
      logic          upd;
      logic [FW-1:0] nxt;
      logic [FW-1:0] q;

      always_comb begin
        upd = cfg_we && (cfg_sel == 3'(r)) && cfg_be[d];
        nxt = cfg_wdata[d*FW +: FW];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= RV;
        else if (upd) q <= nxt;
      end

      assign tim_flat[(r*NDEV+d)*FW +: FW] = q;
    end
  end

  logic en_upd, en_nxt, en_q;

  always_comb begin
    en_upd = cfg_we && (cfg_sel == CFG_CTRL) && cfg_be[NDEV-1];
    en_nxt = cfg_wdata[NDEV*FW-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b1;
    else if (en_upd) en_q <= en_nxt;
  end

  assign en = en_q;
endmodule

// File: rtl/pio_addr_decode.sv
`timescale 1ns/1ps
module pio_addr_decode import pio_pkg::*; #(
  parameter int AW = 10
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic          is_data,
  output logic          is_devreg,
  output logic [1:0]    cs_n,
  output logic [2:0]    da
);
  localparam logic [AW-1:0] CMD_A = AW'(CMD_BASE);
  localparam logic [AW-1:0] ALT_A = AW'(ALT_ADDR);

  logic cmd_hit, alt_hit;

  always_comb begin
    cmd_hit   = (addr[AW-1:3] == CMD_A[AW-1:3]);
    alt_hit   = (addr == ALT_A);
    hit       = cmd_hit || alt_hit;
    is_data   = cmd_hit && (addr[2:0] == 3'd0);
    is_devreg = cmd_hit && (addr[2:0] == DEV_OFS);
    if (cmd_hit) begin
      cs_n = 2'b10;
      da   = addr[2:0];
    end else if (alt_hit) begin
      cs_n = 2'b01;
      da   = ALT_A[2:0];
    end else begin
      cs_n = 2'b11;
      da   = 3'd0;
    end
  end
endmodule

// File: rtl/pio_cycle_fsm.sv
`timescale 1ns/1ps
module pio_cycle_fsm import pio_pkg::*; #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] stb_len,
  input  logic [FW-1:0] rcv_len,
  output cyc_state_e    st,
  output logic          smp,
  output logic          fin
);
  cyc_state_e    st_q, st_d;
  logic [FW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    smp   = 1'b0;
    fin   = 1'b0;
    case (st_q)
      ST_IDLE:   if (start) st_d = ST_SETUP;
      ST_SETUP: begin
        st_d  = ST_ACTIVE;
        cnt_d = stb_len;
      end
      ST_ACTIVE: begin
        if (cnt_q == '0) begin
          smp   = 1'b1;
          st_d  = ST_RECOVER;
          cnt_d = rcv_len;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RECOVER: begin
        if (cnt_q == '0) begin
          fin  = 1'b1;
          st_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    cnt_en = (st_q != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign st = st_q;
endmodule

// File: rtl/pio_timing_gen.sv
`timescale 1ns/1ps
module pio_timing_gen import pio_pkg::*; #(
  parameter int AW          = 10,
  parameter int FW          = 8,
  parameter int CLK_NS      = 5,
  parameter int CYC_NS      = 600,
  parameter int DATA_ACT_NS = 165,
  parameter int REG_ACT_NS  = 290
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_sel,
  input  logic [1:0]      cfg_be,
  input  logic [2*FW-1:0] cfg_wdata,
  input  logic            acc_req,
  input  logic            acc_wr,
  input  logic [AW-1:0]   acc_addr,
  input  logic [2*FW-1:0] acc_wdata,
  output logic            acc_ready,
  output logic            acc_done,
  output logic [2*FW-1:0] acc_rdata,
  output logic [1:0]      ata_cs_n,
  output logic [2:0]      ata_da,
  output logic            ata_dior_n,
  output logic            ata_diow_n,
  output logic [2*FW-1:0] ata_dd_out,
  output logic            ata_dd_oe,
  input  logic [2*FW-1:0] ata_dd_in
);
  localparam int NDEV  = 2;
  localparam int DW    = 2*FW;
  localparam int T_CYC = (CYC_NS + CLK_NS - 1) / CLK_NS;
  localparam int D_ACT = (DATA_ACT_NS + CLK_NS - 1) / CLK_NS;
  localparam int R_ACT = (REG_ACT_NS + CLK_NS - 1) / CLK_NS;
  localparam logic [FW-1:0] DSTB0 = FW'(D_ACT - 1);
  localparam logic [FW-1:0] DRCV0 = FW'(T_CYC - D_ACT - 1);
  localparam logic [FW-1:0] RSTB0 = FW'(R_ACT - 1);
  localparam logic [FW-1:0] RRCV0 = FW'(T_CYC - R_ACT - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  logic [4*NDEV*FW-1:0] tim_flat;
  logic                 en_w;

  pio_timing_regs #(
    .FW(FW), .NDEV(NDEV),
    .DSTB_RST(DSTB0), .DRCV_RST(DRCV0), .RSTB_RST(RSTB0), .RRCV_RST(RRCV0)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .tim_flat(tim_flat), .en(en_w)
  );

  logic       dec_hit, dec_data, dec_devreg;
  logic [1:0] dec_cs_n;
  logic [2:0] dec_da;

  pio_addr_decode #(.AW(AW)) u_dec (
    .addr(acc_addr), .hit(dec_hit), .is_data(dec_data), .is_devreg(dec_devreg),
    .cs_n(dec_cs_n), .da(dec_da)
  );

  cyc_state_e    st;
  logic          smp, fin;
  logic          accept, go, bypass;
  logic [FW-1:0] stb_sel, rcv_sel, stb_q, rcv_q;

  pio_cycle_fsm #(.FW(FW)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .start(go), .stb_len(stb_q), .rcv_len(rcv_q),
    .st(st), .smp(smp), .fin(fin)
  );

  logic          dev_q, dev_upd, dev_nxt;
  logic          wr_q, data_q;
  logic [1:0]    cs_q;
  logic [2:0]    da_q;
  logic [DW-1:0] wdat_q, rdata_q, rdata_d;
  logic          done_q, done_d;
  int unsigned   stb_idx, rcv_idx;

  always_comb begin
    accept  = acc_req && (st == ST_IDLE);
    go      = accept && dec_hit && en_w;
    bypass  = accept && !go;
    dev_upd = go && acc_wr && dec_devreg;
    dev_nxt = acc_wdata[4];
    stb_idx = ((dec_data ? 0 : 2) * NDEV + int'(dev_q)) * FW;
    rcv_idx = ((dec_data ? 1 : 3) * NDEV + int'(dev_q)) * FW;
    stb_sel = tim_flat[stb_idx +: FW];
    rcv_sel = tim_flat[rcv_idx +: FW];
    done_d  = fin || bypass;
    rdata_d = rdata_q;
    if (smp && !wr_q)
      rdata_d = data_q ? ata_dd_in : {{(DW-FW){1'b0}}, ata_dd_in[FW-1:0]};
    else if (bypass && !acc_wr)
      rdata_d = '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wr_q   <= 1'b0;
      data_q <= 1'b0;
      cs_q   <= 2'b11;
      da_q   <= 3'd0;
      wdat_q <= '0;
      stb_q  <= '0;
      rcv_q  <= '0;
    end else if (go) begin
      wr_q   <= acc_wr;
      data_q <= dec_data;
      cs_q   <= dec_cs_n;
      da_q   <= dec_da;
      wdat_q <= acc_wdata;
      stb_q  <= stb_sel;
      rcv_q  <= rcv_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  dev_q <= 1'b0;
    else if (dev_upd) dev_q <= dev_nxt;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      done_q  <= done_d;
    end
  end

  logic busy;
  always_comb begin
    busy       = (st != ST_IDLE);
    acc_ready  = !busy;
    acc_done   = done_q;
    acc_rdata  = rdata_q;
    ata_cs_n   = busy ? cs_q : 2'b11;
    ata_da     = busy ? da_q : 3'd0;
    ata_dior_n = !((st == ST_ACTIVE) && !wr_q);
    ata_diow_n = !((st == ST_ACTIVE) && wr_q);
    ata_dd_oe  = wr_q && ((st == ST_SETUP) || (st == ST_ACTIVE));
    ata_dd_out = wdat_q;
  end
endmodule

// File: rtl/pio_timing_gen_chk.sv
`timescale 1ns/1ps
module pio_timing_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_req,
  input logic       acc_ready,
  input logic       acc_done,
  input logic       en,
  input logic [1:0] cs_n,
  input logic       dior_n,
  input logic       diow_n,
  input logic       dd_oe
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~dior_n, ~diow_n})); // R4

  AST_CS_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dior_n & diow_n) |-> (cs_n != 2'b11) && ($past(cs_n) == cs_n)); // R3

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |-> acc_ready && dior_n && diow_n); // R5

  AST_DISABLED_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_ready && !en) |=> (cs_n == 2'b11) && acc_done); // R9

  AST_OE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dd_oe |-> dior_n); // R10
endmodule

bind pio_timing_gen pio_timing_gen_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .acc_req(acc_req), .acc_ready(acc_ready),
  .acc_done(acc_done), .en(en_w), .cs_n(ata_cs_n), .dior_n(ata_dior_n),
  .diow_n(ata_diow_n), .dd_oe(ata_dd_oe)
);

// File: tb/pio_timing_gen_tb.sv
`timescale 1ns/1ps
module pio_timing_gen_tb_top;
  localparam int CLK_NS = 5;
  localparam int T_CYC  = (600 + CLK_NS - 1) / CLK_NS;
  localparam int D_ACT  = (165 + CLK_NS - 1) / CLK_NS;
  localparam int R_ACT  = (290 + CLK_NS - 1) / CLK_NS;
  localparam int D_RCV  = T_CYC - D_ACT;
  localparam int R_RCV  = T_CYC - R_ACT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [1:0]  cfg_be = '0;
  logic [15:0] cfg_wdata = '0;
  logic        acc_req = 1'b0, acc_wr = 1'b0;
  logic [9:0]  acc_addr = '0;
  logic [15:0] acc_wdata = '0, ata_dd_in = '0;
  logic        acc_ready, acc_done, ata_dior_n, ata_diow_n, ata_dd_oe;
  logic [15:0] acc_rdata, ata_dd_out;
  logic [1:0]  ata_cs_n;
  logic [2:0]  ata_da;

  pio_timing_gen #(.CLK_NS(CLK_NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .acc_req(acc_req), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_ready(acc_ready), .acc_done(acc_done),
    .acc_rdata(acc_rdata), .ata_cs_n(ata_cs_n), .ata_da(ata_da),
    .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n), .ata_dd_out(ata_dd_out),
    .ata_dd_oe(ata_dd_oe), .ata_dd_in(ata_dd_in)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  int          n_set, n_act, n_rcv;
  logic [1:0]  cs_seen;
  logic [2:0]  da_seen;
  logic [15:0] dout_seen;
  logic        oe_any, r_seen, w_seen, busy_bad;

  task automatic cfg_write(input logic [2:0] sel, input logic [1:0] be, input logic [15:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_acc(input logic wr, input logic [9:0] a, input logic [15:0] wd, input logic [15:0] di);
    ata_dd_in = di; acc_wr = wr; acc_addr = a; acc_wdata = wd; acc_req = 1'b1;
    @(negedge clk);
    acc_req = 1'b0;
    n_set = 0; n_act = 0; n_rcv = 0; cs_seen = 2'b11; da_seen = 3'd0;
    dout_seen = '0; oe_any = 1'b0; r_seen = 1'b0; w_seen = 1'b0; busy_bad = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      if (acc_done) break;
      if (acc_ready) busy_bad = 1'b1;
      if (ata_dd_oe) oe_any = 1'b1;
      if (!ata_dior_n) r_seen = 1'b1;
      if (!ata_diow_n) w_seen = 1'b1;
      if (!ata_dior_n || !ata_diow_n) begin
        n_act++;
        dout_seen = ata_dd_out;
      end else if (n_act == 0) begin
        n_set++;
        cs_seen = ata_cs_n;
        da_seen = ata_da;
      end else begin
        n_rcv++;
      end
      @(negedge clk);
    end
  endtask

  task automatic expect_timing(input string req, input int s, input int a, input int r);
    chk(req, "setup clocks", n_set, s);
    chk(req, "strobe clocks", n_act, a);
    chk(req, "recovery clocks", n_rcv, r);
  endtask

  typedef struct packed {
    logic        wr;
    logic [9:0]  addr;
    logic [15:0] wd;
    logic [15:0] di;
    logic [7:0]  act;
    logic [7:0]  rcv;
    logic [1:0]  csn;
    logic [2:0]  da;
    logic [15:0] rd;
  } vec_t;

  // device 0, reset timing (R6)
  localparam vec_t VECS [6] = '{
    '{1'b0, 10'h1F0, 16'h0000, 16'hA5C3, 8'(D_ACT), 8'(D_RCV), 2'b10, 3'd0, 16'hA5C3},
    '{1'b0, 10'h1F7, 16'h0000, 16'h1250, 8'(R_ACT), 8'(R_RCV), 2'b10, 3'd7, 16'h0050},
    '{1'b1, 10'h1F2, 16'h0011, 16'h0000, 8'(R_ACT), 8'(R_RCV), 2'b10, 3'd2, 16'h0000},
    '{1'b0, 10'h3F6, 16'h0000, 16'h7F41, 8'(R_ACT), 8'(R_RCV), 2'b01, 3'd6, 16'h0041},
    '{1'b1, 10'h1F0, 16'hBEEF, 16'h0000, 8'(D_ACT), 8'(D_RCV), 2'b10, 3'd0, 16'h0000},
    '{1'b0, 10'h100, 16'h0000, 16'h3333, 8'd0,      8'd0,      2'b11, 3'd0, 16'h0000}
  };

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "ready", acc_ready, 1);
    chk("R1", "done", acc_done, 0);
    chk("R1", "cs_n", ata_cs_n, 2'b11);
    chk("R1", "strobes", {ata_dior_n, ata_diow_n}, 2'b11);
    chk("R1", "dd_oe", ata_dd_oe, 0);

    foreach (VECS[k]) begin
      vec_t v;
      v = VECS[k];
      run_acc(v.wr, v.addr, v.wd, v.di);
      expect_timing("R3 R4 R5 R6", (v.act == 0) ? 0 : 1, int'(v.act), int'(v.rcv));
      chk("R2", "cs_n", cs_seen, v.csn);
      chk("R2", "da", da_seen, v.da);
      chk("R5", "ready low while busy", busy_bad, 0);
      if (v.act != 0) begin
        chk("R4", "read strobe used", r_seen, !v.wr);
        chk("R4", "write strobe used", w_seen, v.wr);
      end
      if (v.wr) chk("R10", "dd_out", dout_seen, v.wd);
      else begin
        chk("R10", "read data", acc_rdata, v.rd);
        chk("R10", "no oe on read", oe_any, 0);
      end
      @(negedge clk);
      chk("R5", "done is one pulse", acc_done, 0);
    end

    // R7: device 1 bytes only
    cfg_write(3'd0, 2'b10, 16'h0300);
    cfg_write(3'd1, 2'b10, 16'h0400);
    run_acc(1'b0, 10'h1F0, 16'h0, 16'h1111);
    expect_timing("R7 dev0 data kept", 1, D_ACT, D_RCV);
    // R8: device-register write uses the old device
    run_acc(1'b1, 10'h1F6, 16'h0010, 16'h0);
    expect_timing("R8 devreg old timing", 1, R_ACT, R_RCV);
    run_acc(1'b0, 10'h1F0, 16'h0, 16'h2222);
    expect_timing("R8 dev1 data", 1, 4, 5);
    chk("R8", "read data", acc_rdata, 16'h2222);
    run_acc(1'b0, 10'h1F1, 16'h0, 16'h0);
    expect_timing("R7 dev1 reg kept", 1, R_ACT, R_RCV);
    cfg_write(3'd0, 2'b01, 16'hFF02);
    run_acc(1'b0, 10'h1F0, 16'h0, 16'h0);
    expect_timing("R7 dev1 byte kept", 1, 4, 5);

    // R9: disabled interface
    cfg_write(3'd4, 2'b11, 16'h0000);
    run_acc(1'b0, 10'h1F0, 16'h0, 16'h5A5A);
    expect_timing("R9 disabled", 0, 0, 0);
    chk("R9", "rdata zero", acc_rdata, 16'h0);
    run_acc(1'b1, 10'h1F6, 16'h0000, 16'h0);
    expect_timing("R9 disabled devreg", 0, 0, 0);
    cfg_write(3'd4, 2'b11, 16'h8000);
    run_acc(1'b0, 10'h1F0, 16'h0, 16'h0);
    expect_timing("R9 device unchanged", 1, 4, 5);

    // R8: back to device 0
    run_acc(1'b1, 10'h1F6, 16'h0000, 16'h0);
    expect_timing("R8 devreg dev1 reg", 1, R_ACT, R_RCV);
    run_acc(1'b0, 10'h1F0, 16'h0, 16'h0);
    expect_timing("R8 dev0 new strobe", 1, 3, D_RCV);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule